// File: doc/BRIEF.md
# Sleep Mode Entry and Wake Controller

This block decides when a small processor core goes to sleep and when it wakes. The core raises a one-cycle sleep strobe. If the standby-select input is low, the block enters sleep and holds the core halted. The core's registers are left exactly as they were, because the block only gates execution and never clears or resets the core. If standby-select is high, the block does not sleep. It hands the request on through a one-cycle standby-request pulse, since standby mode itself is handled elsewhere. Peripheral clocks and the external clock output remain enabled throughout sleep.

While asleep, the block watches four kinds of wake event. A manual reset always wakes it, and a bus error wakes it next in rank. Below those comes an interrupt that is accepted against the core's mask level. An interrupt is accepted when the non-maskable request is present. It is also accepted when a maskable source is pending and the incoming priority is strictly above the mask. The maskable sources are the debug-port, external-line, pin-change and peripheral interrupts, and a peripheral interrupt counts only while its module-side enable is set. Priority ranking across sources is done upstream: the block sees only the winning priority. On waking, it releases the halt, emits a one-cycle wake pulse and reports the cause. A power-on reset on the block's asynchronous reset returns everything to the awake state.

Top module: `sleep_mode_ctl`

## Requirements
- R1: A sleep strobe seen while awake with standby-select low, and with no manual reset in the same cycle, sets the halt output high from the next cycle on.
- R2: A sleep strobe seen while awake with standby-select high leaves the halt output low and produces a standby-request pulse exactly one cycle long in the next cycle.
- R3: Once out of reset, the peripheral clock enable and the clock output enable are high, including every cycle spent asleep.
- R4: While asleep, a pending debug, external-line or pin-change interrupt wakes the block only when its 4-bit priority is strictly greater than the 4-bit mask level. An equal or lower priority, or a priority with no pending source, leaves the halt output high.
- R5: The non-maskable interrupt counts as priority 16 and therefore wakes the block for any mask value from 0 to 15.
- R6: A peripheral interrupt wakes the block only while its module enable input is high. With the enable low, it leaves the block asleep.
- R7: A bus error while asleep wakes the block with wake cause 2'b10.
- R8: A manual reset while asleep wakes the block with wake cause 2'b11. An asserted power-on reset (low on the asynchronous reset) forces the halt output low, the wake pulse low and the wake cause to 2'b00.
- R9: When several wake events coincide, manual reset (cause 2'b11) outranks bus error (cause 2'b10), and bus error outranks an accepted interrupt (cause 2'b01).
- R10: A wake raises the wake pulse for exactly one cycle, in the same cycle the halt drops, with the new cause already valid. The cause then holds until the next wake. Wake events arriving while awake produce no pulse and leave the cause unchanged.
- R11: A sleep strobe arriving while already asleep is ignored, and the block stays asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| sleepStrobe | input | 1 | One-cycle sleep instruction strobe from the core |
| standbySel | input | 1 | Selects standby (1) instead of sleep (0) |
| nmiReq | input | 1 | Non-maskable interrupt request |
| dbgReq | input | 1 | Debug-port interrupt request |
| irqReq | input | 1 | External interrupt line request |
| pinReq | input | 1 | Pin-change interrupt request |
| perReq | input | 1 | Peripheral interrupt request |
| perEnable | input | 1 | Module-side enable for the peripheral interrupt |
| reqPriority | input | PRIO_W | Priority of the highest pending maskable request |
| maskLevel | input | PRIO_W | Core interrupt mask level |
| busError | input | 1 | Bus error indication |
| manualReset | input | 1 | Synchronous manual reset request |
| cpuHalt | output | 1 | Holds the core halted while asleep |
| periphClkEn | output | 1 | Peripheral clock enable |
| clkOutEn | output | 1 | External clock output enable |
| standbyReq | output | 1 | One-cycle pulse requesting standby |
| wakePulse | output | 1 | One-cycle pulse on wake |
| wakeCause | output | 2 | 01 interrupt, 10 bus error, 11 reset, 00 none |

## Verification
The assertions check on every cycle that the block halts after a qualifying strobe and that clocks stay enabled while halted. They also check that an interrupt at or below the mask, or a disabled peripheral request, never ends sleep, that NMI and bus error always end it with the right cause, that manual reset wins, and that the wake pulse is a single cycle aligned with the halt falling. Only the bench scenarios show the full priority-versus-mask table across sources and the cause holding after the pulse. They also show that wake inputs are ignored while awake, that a repeated strobe during sleep has no effect, and that power-on reset clears the block in mid-sleep.

// File: rtl/sleep_ctl_pkg.sv
package sleep_ctl_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_INTR   = 2'b01,
    CAUSE_BUSERR = 2'b10,
    CAUSE_RESET  = 2'b11
  } wake_cause_e;

  typedef enum logic {
    ST_AWAKE = 1'b0,
    ST_SLEEP = 1'b1
  } sleep_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic enterSleep;
    logic fireWake;
    logic fireStandby;
  } ctl_strobe_t;

endpackage

// File: rtl/sleep_wake_path.sv
module sleep_wake_path
  import sleep_ctl_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiReq,
  input  logic              dbgReq,
  input  logic              irqReq,
  input  logic              pinReq,
  input  logic              perReq,
  input  logic              perEnable,
  input  logic [PRIO_W-1:0] reqPriority,
  input  logic [PRIO_W-1:0] maskLevel,
  input  logic              busError,
  input  logic              manualReset,
  input  ctl_strobe_t       ctl,
  output logic              wakeHit,
  output logic              wakePulse,
  output logic [1:0]        wakeCause,
  output logic              standbyReq
);

  localparam int EXT_W = PRIO_W + 1;
  localparam int SRC_N = 4;
  localparam logic [EXT_W-1:0] NMI_LEVEL = EXT_W'(1) << PRIO_W;

  logic [SRC_N-1:0] srcVec;
  logic             anyMaskable;
  logic [EXT_W-1:0] effPriority;
  logic [EXT_W-1:0] effMask;
  logic             intAccept;
  wake_cause_e      causeNext;
  wake_cause_e      causeReg;

  // peripheral request counts only when its module enables it
  assign srcVec      = {dbgReq, irqReq, pinReq, perReq & perEnable};
  assign anyMaskable = |srcVec;

  assign effPriority = nmiReq ? NMI_LEVEL : {1'b0, reqPriority};
  assign effMask     = {1'b0, maskLevel};
  assign intAccept   = (nmiReq | anyMaskable) && (effPriority > effMask);

  // fixed ranking: reset, bus error, interrupt
  always_comb begin
    if (manualReset)    causeNext = CAUSE_RESET;
    else if (busError)  causeNext = CAUSE_BUSERR;
    else if (intAccept) causeNext = CAUSE_INTR;
    else                causeNext = CAUSE_NONE;
  end

  assign wakeHit = (causeNext != CAUSE_NONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakePulse  <= 1'b0;
      standbyReq <= 1'b0;
      causeReg   <= CAUSE_NONE;
    end else begin
      wakePulse  <= ctl.fireWake;
      standbyReq <= ctl.fireStandby;
      if (ctl.fireWake) causeReg <= causeNext;
    end
  end

  assign wakeCause = causeReg;

endmodule

// File: rtl/sleep_ctl_fsm.sv
module sleep_ctl_fsm
  import sleep_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepStrobe,
  input  logic        standbySel,
  input  logic        manualReset,
  input  logic        wakeHit,
  output ctl_strobe_t ctl,
  output logic        asleep,
  output logic        clkRun
);

  sleep_state_e state;
  sleep_state_e stateNext;
  logic         awakeStrobe;

  assign awakeStrobe = (state == ST_AWAKE) && sleepStrobe && !manualReset;

  always_comb begin
    ctl.enterSleep  = awakeStrobe && !standbySel;
    ctl.fireStandby = awakeStrobe && standbySel;
    ctl.fireWake    = (state == ST_SLEEP) && wakeHit;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_AWAKE: if (ctl.enterSleep) stateNext = ST_SLEEP;
      ST_SLEEP: if (ctl.fireWake)   stateNext = ST_AWAKE;
      default:                      stateNext = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_AWAKE;
      clkRun <= 1'b0;
    end else begin
      state  <= stateNext;
      clkRun <= 1'b1;
    end
  end

  assign asleep = (state == ST_SLEEP);

endmodule

// File: rtl/sleep_mode_ctl.sv
module sleep_mode_ctl
  import sleep_ctl_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleepStrobe,
  input  logic              standbySel,
  input  logic              nmiReq,
  input  logic              dbgReq,
  input  logic              irqReq,
  input  logic              pinReq,
  input  logic              perReq,
  input  logic              perEnable,
  input  logic [PRIO_W-1:0] reqPriority,
  input  logic [PRIO_W-1:0] maskLevel,
  input  logic              busError,
  input  logic              manualReset,
  output logic              cpuHalt,
  output logic              periphClkEn,
  output logic              clkOutEn,
  output logic              standbyReq,
  output logic              wakePulse,
  output logic [1:0]        wakeCause
);

  ctl_strobe_t ctl;
  logic        wakeHit;
  logic        asleep;
  logic        clkRun;

  sleep_ctl_fsm u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .sleepStrobe (sleepStrobe),
    .standbySel  (standbySel),
    .manualReset (manualReset),
    .wakeHit     (wakeHit),
    .ctl         (ctl),
    .asleep      (asleep),
    .clkRun      (clkRun)
  );

  sleep_wake_path #(.PRIO_W(PRIO_W)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .nmiReq      (nmiReq),
    .dbgReq      (dbgReq),
    .irqReq      (irqReq),
    .pinReq      (pinReq),
    .perReq      (perReq),
    .perEnable   (perEnable),
    .reqPriority (reqPriority),
    .maskLevel   (maskLevel),
    .busError    (busError),
    .manualReset (manualReset),
    .ctl         (ctl),
    .wakeHit     (wakeHit),
    .wakePulse   (wakePulse),
    .wakeCause   (wakeCause),
    .standbyReq  (standbyReq)
  );

  assign cpuHalt     = asleep;
  assign periphClkEn = clkRun;
  assign clkOutEn    = clkRun;

endmodule

// File: rtl/sleep_mode_ctl_chk.sv
module sleep_mode_ctl_chk #(
  parameter int PRIO_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              sleepStrobe,
  input logic              standbySel,
  input logic              nmiReq,
  input logic              dbgReq,
  input logic              irqReq,
  input logic              pinReq,
  input logic              perReq,
  input logic              perEnable,
  input logic [PRIO_W-1:0] reqPriority,
  input logic [PRIO_W-1:0] maskLevel,
  input logic              busError,
  input logic              manualReset,
  input logic              cpuHalt,
  input logic              periphClkEn,
  input logic              clkOutEn,
  input logic              standbyReq,
  input logic              wakePulse,
  input logic [1:0]        wakeCause
);

  p_enter_halt_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuHalt && sleepStrobe && !standbySel && !manualReset) |=> cpuHalt);

  p_standby_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuHalt && sleepStrobe && standbySel && !manualReset) |=> (standbyReq && !cpuHalt));

  p_clocks_on_r3: assert property (@(posedge clk) disable iff (!rstN)
    cpuHalt |-> (periphClkEn && clkOutEn));

  p_low_prio_stays_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuHalt && !nmiReq && !busError && !manualReset && (reqPriority <= maskLevel))
      |=> cpuHalt);

  p_nmi_wakes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuHalt && nmiReq) |=> (!cpuHalt && wakePulse));

  p_per_disabled_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuHalt && perReq && !perEnable && !nmiReq && !dbgReq && !irqReq && !pinReq
      && !busError && !manualReset) |=> cpuHalt);

  p_buserr_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cpuHalt && busError && !manualReset) |=> (wakePulse && wakeCause == 2'b10));

  p_reset_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuHalt && manualReset) |=> (wakePulse && wakeCause == 2'b11));

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  p_pulse_ends_halt_r10: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (!cpuHalt && $past(cpuHalt)));

endmodule

bind sleep_mode_ctl sleep_mode_ctl_chk #(.PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/sleep_mode_ctl_test.sv
`timescale 1ns/1ps
module sleep_mode_ctl_test;

  localparam int PRIO_W = 4;
  localparam int NVEC   = 13;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, sleepStrobe, standbySel, nmiReq, dbgReq, irqReq, pinReq;
  logic perReq, perEnable, busError, manualReset;
  logic [PRIO_W-1:0] reqPriority, maskLevel;
  logic cpuHalt, periphClkEn, clkOutEn, standbyReq, wakePulse;
  logic [1:0] wakeCause;

  sleep_mode_ctl #(.PRIO_W(PRIO_W)) uut (
    .clk(clk), .rstN(rstN), .sleepStrobe(sleepStrobe), .standbySel(standbySel),
    .nmiReq(nmiReq), .dbgReq(dbgReq), .irqReq(irqReq), .pinReq(pinReq),
    .perReq(perReq), .perEnable(perEnable), .reqPriority(reqPriority),
    .maskLevel(maskLevel), .busError(busError), .manualReset(manualReset),
    .cpuHalt(cpuHalt), .periphClkEn(periphClkEn), .clkOutEn(clkOutEn),
    .standbyReq(standbyReq), .wakePulse(wakePulse), .wakeCause(wakeCause)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // {nmi,dbg,irq,pin,per,perEn, pri, mask, bus, man, expWake, expCause}
  localparam logic [18:0] VECS [NVEC] = '{
    {6'b001000, 4'd5,  4'd4,  2'b00, 1'b1, 2'b01},
    {6'b001000, 4'd4,  4'd4,  2'b00, 1'b0, 2'b00},
    {6'b001000, 4'd3,  4'd4,  2'b00, 1'b0, 2'b00},
    {6'b010000, 4'd1,  4'd0,  2'b00, 1'b1, 2'b01},
    {6'b000100, 4'd15, 4'd14, 2'b00, 1'b1, 2'b01},
    {6'b100000, 4'd0,  4'd15, 2'b00, 1'b1, 2'b01},
    {6'b000010, 4'd9,  4'd2,  2'b00, 1'b0, 2'b00},
    {6'b000011, 4'd9,  4'd2,  2'b00, 1'b1, 2'b01},
    {6'b000000, 4'd0,  4'd0,  2'b10, 1'b1, 2'b10},
    {6'b000000, 4'd0,  4'd0,  2'b01, 1'b1, 2'b11},
    {6'b001000, 4'd7,  4'd1,  2'b10, 1'b1, 2'b10},
    {6'b100000, 4'd0,  4'd0,  2'b11, 1'b1, 2'b11},
    {6'b000000, 4'd9,  4'd2,  2'b00, 1'b0, 2'b00}
  };

  function automatic string reqOf(int idx);
    case (idx)
      0, 1, 2, 3, 4, 12: return "R4";
      5:                 return "R5";
      6, 7:              return "R6";
      8:                 return "R7";
      9:                 return "R8";
      default:           return "R9";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [3:0] act, logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearInputs();
    sleepStrobe = 0; standbySel = 0; nmiReq = 0; dbgReq = 0; irqReq = 0;
    pinReq = 0; perReq = 0; perEnable = 0; busError = 0; manualReset = 0;
    reqPriority = '0; maskLevel = '0;
  endtask

  task automatic goSleep();
    @(negedge clk);
    sleepStrobe = 1; standbySel = 0;
    @(negedge clk);
    sleepStrobe = 0;
    chk("R1", "halt after strobe", {3'b0, cpuHalt}, 4'd1);
    chk("R3", "clocks in sleep", {2'b0, periphClkEn, clkOutEn}, 4'b0011);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    clearInputs();
    rstN = 0;
    repeat (3) @(negedge clk);
    chk("R8", "reset halt", {3'b0, cpuHalt}, 4'd0);
    chk("R8", "reset pulse", {3'b0, wakePulse}, 4'd0);
    chk("R8", "reset cause", {2'b0, wakeCause}, 4'd0);
    rstN = 1;
    @(negedge clk);
    chk("R3", "clocks awake", {2'b0, periphClkEn, clkOutEn}, 4'b0011);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [18:0] v;
      v = VECS[i];
      goSleep();
      {nmiReq, dbgReq, irqReq, pinReq, perReq, perEnable} = v[18:13];
      reqPriority = v[12:9];
      maskLevel   = v[8:5];
      busError    = v[4];
      manualReset = v[3];
      @(negedge clk);
      clearInputs();
      chk(reqOf(i), "wake pulse", {3'b0, wakePulse}, {3'b0, v[2]});
      chk(reqOf(i), "halt after stimulus", {3'b0, cpuHalt}, {3'b0, ~v[2]});
      if (v[2]) begin
        chk(reqOf(i), "wake cause", {2'b0, wakeCause}, {2'b0, v[1:0]});
        @(negedge clk);
        chk("R10", "pulse one cycle", {3'b0, wakePulse}, 4'd0);
        chk("R10", "cause held", {2'b0, wakeCause}, {2'b0, v[1:0]});
      end else begin
        manualReset = 1;
        @(negedge clk);
        manualReset = 0;
        chk("R8", "manual reset wake", {1'b0, cpuHalt, wakeCause}, 4'b0011);
      end
    end

    // standby request path
    @(negedge clk);
    sleepStrobe = 1; standbySel = 1;
    @(negedge clk);
    clearInputs();
    chk("R2", "standby pulse", {3'b0, standbyReq}, 4'd1);
    chk("R2", "no halt on standby", {3'b0, cpuHalt}, 4'd0);
    @(negedge clk);
    chk("R2", "standby pulse ends", {3'b0, standbyReq}, 4'd0);

    // repeated strobe while asleep
    goSleep();
    sleepStrobe = 1;
    @(negedge clk);
    sleepStrobe = 0;
    chk("R11", "still asleep", {3'b0, cpuHalt}, 4'd1);
    chk("R11", "no standby", {3'b0, standbyReq}, 4'd0);
    @(negedge clk);
    chk("R11", "asleep later", {2'b0, cpuHalt, wakePulse}, 4'b0010);
    busError = 1;
    @(negedge clk);
    busError = 0;
    chk("R7", "bus error wake", {1'b0, cpuHalt, wakeCause}, 4'b0010);

    // wake events while awake are ignored
    @(negedge clk);
    manualReset = 1; nmiReq = 1;
    @(negedge clk);
    clearInputs();
    chk("R10", "no pulse awake", {3'b0, wakePulse}, 4'd0);
    chk("R10", "cause unchanged awake", {2'b0, wakeCause}, 4'b0010);

    // manual reset blocks a same-cycle strobe
    sleepStrobe = 1; manualReset = 1;
    @(negedge clk);
    clearInputs();
    chk("R1", "reset blocks entry", {3'b0, cpuHalt}, 4'd0);

    // power-on reset mid-sleep
    goSleep();
    #1 rstN = 0;
    #1;
    chk("R8", "por clears halt", {1'b0, cpuHalt, wakeCause}, 4'd0);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R8", "awake after por", {2'b0, cpuHalt, wakePulse}, 4'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule